// File: doc/BRIEF.md
# Descriptor-DMA Register Block with Status and Interrupt

This block is the software-visible register space of a descriptor-based network DMA engine. A word-addressed bus writes and reads a 1024-word window. Most words are plain storage. A handful carry side effects: the bus-mode word, the transmit poll trigger, the two list-base words that also load the live descriptor pointers, and the status word with write-one-to-clear semantics. A fixed identification word returns a constant.

The transmit and receive engines report events on single-cycle request lines. Each request sets a pair of status bits: the event bit and its summary bit. A single level interrupt is raised whenever a status bit is set whose enable bit is also set. The engines take the control word, the bus-mode word, the live descriptor pointers and the poll trigger directly from the block's outputs.

Top module: `dmareg_top`

## Requirements
- R1: The word index is the byte address shifted right by 2, so the two low address bits are ignored. A word index of 1024 or above reads as zero, and writes to it change nothing.
- R2: A write to word 0x3C5 (status) clears each status bit written as 1 and leaves the other bits as they were.
- R3: `irq` is high exactly when the bitwise AND of status and word 0x3C7 (interrupt enable) is nonzero. It reflects every write and every engine request from the cycle after the clock edge that applied it.
- R4: Reading word 0x08 always returns 0x1012, even after that word has been written.
- R5: A write to word 0x3C0 (bus mode) stores the data with bit 0 forced to 0. The stored value appears on `bus_mode`.
- R6: A write to word 0x3C3 stores the data in both 0x3C3 and 0x3D3 (receive current pointer, on `rx_cur`). A write to word 0x3C4 stores it in both 0x3C4 and 0x3D2 (transmit current pointer, on `tx_cur`).
- R7: `tx_done` sets status bits 0 and 16. `rx_done` sets status bits 6 and 16. `rx_nodesc` sets status bits 7 and 15.
- R8: If an engine request and a software clear target the same status bit in the same cycle, the bit ends up set.
- R9: A write to word 0x3C1 (transmit poll) raises `tx_poll` for exactly the one cycle after the write edge. That word stores nothing and keeps reading its reset value of 0.
- R10: Every other in-range word, including control at 0x3C6 and interrupt enable at 0x3C7, reads back the last value written. Word 0x3C6 appears on `dma_ctrl`.
- R11: After reset, every stored word and the status word read 0, and `irq` and `tx_poll` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (14) | Byte address of the access |
| bus_wr | input | 1 | Write strobe, applied at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_done | input | 1 | Transmit engine finished a frame |
| rx_done | input | 1 | Receive engine stored a frame |
| rx_nodesc | input | 1 | Receive engine found no free descriptor |
| tx_poll | output | 1 | One-cycle transmit poll trigger |
| irq | output | 1 | Level interrupt |
| dma_ctrl | output | 32 | Control word |
| bus_mode | output | 32 | Bus-mode word |
| rx_cur | output | 32 | Receive current descriptor pointer |
| tx_cur | output | 32 | Transmit current descriptor pointer |

## Verification
The bench aims a status clear at the same bit an engine is setting in that cycle. A design that lets the clear win would lose the event and drop `irq`. Base-address writes are checked through both the base word and the current-pointer word, so a design that updates only one of them reads back stale pointers. Addresses with nonzero low bits are used to catch a design that decodes those bits. Addresses at 1024 words and above are used to catch a design that aliases them onto low words. Writes to the identification and poll words are followed by reads, which show any design that stores them.

// File: rtl/dmareg_pkg.sv
package dmareg_pkg;

    localparam int unsigned DW = 32;

    // word indices whose behaviour differs from plain storage
    localparam int unsigned W_IDENT   = 'h008;
    localparam int unsigned W_BUSMODE = 'h3C0;
    localparam int unsigned W_POLL    = 'h3C1;
    localparam int unsigned W_RXBASE  = 'h3C3;
    localparam int unsigned W_TXBASE  = 'h3C4;
    localparam int unsigned W_STATUS  = 'h3C5;
    localparam int unsigned W_CTRL    = 'h3C6;
    localparam int unsigned W_INTEN   = 'h3C7;
    localparam int unsigned W_TXCUR   = 'h3D2;
    localparam int unsigned W_RXCUR   = 'h3D3;

    localparam logic [DW-1:0] IDENT_VALUE = 32'h0000_1012;

    // status bit positions
    localparam int unsigned SB_TXI = 0;
    localparam int unsigned SB_RXI = 6;
    localparam int unsigned SB_RXU = 7;
    localparam int unsigned SB_ABN = 15;
    localparam int unsigned SB_NRM = 16;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_PLAIN,
        ACC_BUSMODE,
        ACC_POLL,
        ACC_STATUS,
        ACC_RXBASE,
        ACC_TXBASE
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;      // write action for this cycle
        logic      in_range;  // word index inside the window
        logic      rd_ident;  // read hits the identification word
        logic      rd_status; // read hits the status word
    } acc_t;

    function automatic logic [DW-1:0] engine_set(input logic tx_ev,
                                                 input logic rx_ev,
                                                 input logic nodesc_ev);
        logic [DW-1:0] m;
        m = '0;
        if (tx_ev) begin
            m[SB_TXI] = 1'b1;
            m[SB_NRM] = 1'b1;
        end
        if (rx_ev) begin
            m[SB_RXI] = 1'b1;
            m[SB_NRM] = 1'b1;
        end
        if (nodesc_ev) begin
            m[SB_RXU] = 1'b1;
            m[SB_ABN] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] busmode_fix(input logic [DW-1:0] d);
        return {d[DW-1:1], 1'b0};
    endfunction

endpackage

// File: rtl/dmareg_decode.sv
module dmareg_decode
    import dmareg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned SPACE_WORDS = 1024
) (
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr,
    output acc_t                           acc,
    output logic [$clog2(SPACE_WORDS)-1:0] idx
);
    localparam int unsigned WIDX_W = ADDR_W - 2;
    localparam int unsigned IDX_W  = $clog2(SPACE_WORDS);

    logic [WIDX_W-1:0] widx;
    logic              lsb_unused;

    assign widx       = addr[ADDR_W-1:2];
    assign lsb_unused = ^addr[1:0];
    assign idx        = widx[IDX_W-1:0];

    always_comb begin
        acc           = '0;
        acc.kind      = ACC_NONE;
        acc.in_range  = ({1'b0, widx} < (WIDX_W+1)'(SPACE_WORDS));
        acc.rd_ident  = acc.in_range && (widx == WIDX_W'(W_IDENT));
        acc.rd_status = acc.in_range && (widx == WIDX_W'(W_STATUS));
        if (wr && acc.in_range) begin
            if (widx == WIDX_W'(W_BUSMODE))     acc.kind = ACC_BUSMODE;
            else if (widx == WIDX_W'(W_POLL))   acc.kind = ACC_POLL;
            else if (widx == WIDX_W'(W_STATUS)) acc.kind = ACC_STATUS;
            else if (widx == WIDX_W'(W_RXBASE)) acc.kind = ACC_RXBASE;
            else if (widx == WIDX_W'(W_TXBASE)) acc.kind = ACC_TXBASE;
            else                                acc.kind = ACC_PLAIN;
        end
    end
endmodule

// File: rtl/dmareg_store.sv
module dmareg_store
    import dmareg_pkg::*;
#(
    parameter int unsigned SPACE_WORDS = 1024,
    localparam int unsigned IDX_W      = $clog2(SPACE_WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_kind_e        kind,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rd_word,
    output logic [DW-1:0]    ctrl_word,
    output logic [DW-1:0]    inten_word,
    output logic [DW-1:0]    busmode_word,
    output logic [DW-1:0]    rxcur_word,
    output logic [DW-1:0]    txcur_word
);
    logic [DW-1:0] mem [SPACE_WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(SPACE_WORDS); i++) begin
                mem[i] <= '0;
            end
        end else begin
            unique case (kind)
                ACC_PLAIN:   mem[idx] <= wdata;
                ACC_BUSMODE: mem[idx] <= busmode_fix(wdata);
                ACC_RXBASE: begin
                    mem[idx]             <= wdata;
                    mem[IDX_W'(W_RXCUR)] <= wdata;
                end
                ACC_TXBASE: begin
                    mem[idx]             <= wdata;
                    mem[IDX_W'(W_TXCUR)] <= wdata;
                end
                default: ;
            endcase
        end
    end

    assign rd_word      = mem[idx];
    assign ctrl_word    = mem[IDX_W'(W_CTRL)];
    assign inten_word   = mem[IDX_W'(W_INTEN)];
    assign busmode_word = mem[IDX_W'(W_BUSMODE)];
    assign rxcur_word   = mem[IDX_W'(W_RXCUR)];
    assign txcur_word   = mem[IDX_W'(W_TXCUR)];
endmodule

// File: rtl/dmareg_status.sv
module dmareg_status
    import dmareg_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_en,
    input  logic [DW-1:0] clr_mask,
    input  logic [DW-1:0] set_mask,
    output logic [DW-1:0] status_q
);
    logic [DW-1:0] keep_mask;

    assign keep_mask = clr_en ? ~clr_mask : '1;

    // set requests are merged after the clear, so they take priority
    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= (status_q & keep_mask) | set_mask;
    end
endmodule

// File: rtl/dmareg_top.sv
module dmareg_top
    import dmareg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned SPACE_WORDS = 1024
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic              tx_done,
    input  logic              rx_done,
    input  logic              rx_nodesc,
    output logic              tx_poll,
    output logic              irq,
    output logic [DW-1:0]     dma_ctrl,
    output logic [DW-1:0]     bus_mode,
    output logic [DW-1:0]     rx_cur,
    output logic [DW-1:0]     tx_cur
);
    localparam int unsigned IDX_W = $clog2(SPACE_WORDS);

    acc_t             acc;
    logic [IDX_W-1:0] idx;
    logic [DW-1:0]    store_rd;
    logic [DW-1:0]    inten;
    logic [DW-1:0]    status_q;
    logic [DW-1:0]    set_mask;
    logic             poll_q;

    dmareg_decode #(
        .ADDR_W      (ADDR_W),
        .SPACE_WORDS (SPACE_WORDS)
    ) u_dec (
        .addr (bus_addr),
        .wr   (bus_wr),
        .acc  (acc),
        .idx  (idx)
    );

    dmareg_store #(
        .SPACE_WORDS (SPACE_WORDS)
    ) u_store (
        .clk          (clk),
        .rst          (rst),
        .kind         (acc.kind),
        .idx          (idx),
        .wdata        (bus_wdata),
        .rd_word      (store_rd),
        .ctrl_word    (dma_ctrl),
        .inten_word   (inten),
        .busmode_word (bus_mode),
        .rxcur_word   (rx_cur),
        .txcur_word   (tx_cur)
    );

    assign set_mask = engine_set(tx_done, rx_done, rx_nodesc);

    dmareg_status u_stat (
        .clk      (clk),
        .rst      (rst),
        .clr_en   (acc.kind == ACC_STATUS),
        .clr_mask (bus_wdata),
        .set_mask (set_mask),
        .status_q (status_q)
    );

    always_ff @(posedge clk) begin
        if (rst) poll_q <= 1'b0;
        else     poll_q <= (acc.kind == ACC_POLL);
    end
    assign tx_poll = poll_q;

    always_comb begin
        if (!acc.in_range)     bus_rdata = '0;
        else if (acc.rd_ident) bus_rdata = IDENT_VALUE;
        else if (acc.rd_status) bus_rdata = status_q;
        else                   bus_rdata = store_rd;
    end

    assign irq = |(status_q & inten);
endmodule

// File: rtl/dmareg_chk.sv
module dmareg_chk
    import dmareg_pkg::*;
#(
    parameter int unsigned ADDR_W      = 14,
    parameter int unsigned SPACE_WORDS = 1024
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DW-1:0]     bus_wdata,
    input logic [DW-1:0]     bus_rdata,
    input logic              tx_done,
    input logic              rx_done,
    input logic              rx_nodesc,
    input logic              tx_poll,
    input logic              irq,
    input logic [DW-1:0]     bus_mode,
    input logic [DW-1:0]     rx_cur,
    input logic [DW-1:0]     tx_cur,
    input logic [DW-1:0]     status_q
);
    localparam int unsigned WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    logic              low_unused;
    logic              quiet;
    logic              wr_status;

    assign widx       = bus_addr[ADDR_W-1:2];
    assign low_unused = ^bus_addr[1:0];
    assign quiet      = !tx_done && !rx_done && !rx_nodesc;
    assign wr_status  = bus_wr && (widx == WIDX_W'(W_STATUS));

    a_r1_outside_reads_zero: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, widx} >= (WIDX_W+1)'(SPACE_WORDS)) |-> (bus_rdata == '0));

    a_r2_write_one_clears: assert property (@(posedge clk) disable iff (rst)
        (wr_status && quiet) |=> (status_q == ($past(status_q) & ~$past(bus_wdata))));

    a_r3_irq_drops_on_full_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_status && (bus_wdata == '1) && quiet) |=> !irq);

    a_r4_ident_fixed: assert property (@(posedge clk) disable iff (rst)
        (widx == WIDX_W'(W_IDENT)) |-> (bus_rdata == IDENT_VALUE));

    a_r5_busmode_bit0: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (widx == WIDX_W'(W_BUSMODE))) |=> (bus_mode == {$past(bus_wdata[DW-1:1]), 1'b0}));

    a_r6_rx_base_loads_cur: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (widx == WIDX_W'(W_RXBASE))) |=> (rx_cur == $past(bus_wdata)));

    a_r6_tx_base_loads_cur: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (widx == WIDX_W'(W_TXBASE))) |=> (tx_cur == $past(bus_wdata)));

    a_r7_nodesc_sets: assert property (@(posedge clk) disable iff (rst)
        rx_nodesc |=> (status_q[SB_RXU] && status_q[SB_ABN]));

    a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_status && rx_done) |=> (status_q[SB_RXI] && status_q[SB_NRM]));

    a_r9_poll_pulses: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && (widx == WIDX_W'(W_POLL))) |=> tx_poll);

    a_r9_poll_only_after_write: assert property (@(posedge clk) disable iff (rst)
        tx_poll |-> $past(bus_wr && (widx == WIDX_W'(W_POLL))));
endmodule

bind dmareg_top dmareg_chk #(
    .ADDR_W      (ADDR_W),
    .SPACE_WORDS (SPACE_WORDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .tx_done   (tx_done),
    .rx_done   (rx_done),
    .rx_nodesc (rx_nodesc),
    .tx_poll   (tx_poll),
    .irq       (irq),
    .bus_mode  (bus_mode),
    .rx_cur    (rx_cur),
    .tx_cur    (tx_cur),
    .status_q  (status_q)
);

// File: tb/sim_dmareg_top.sv
`timescale 1ns/1ps
module sim_dmareg_top;
    localparam int AW = 14;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          tx_done = 1'b0, rx_done = 1'b0, rx_nodesc = 1'b0;
    logic          tx_poll, irq;
    logic [31:0]   dma_ctrl, bus_mode, rx_cur, tx_cur;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [31:0] m [0:1023];
    logic [31:0] m_st;

    always #10 clk = ~clk;

    dmareg_top #(.ADDR_W(AW), .SPACE_WORDS(1024)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_done(tx_done),
        .rx_done(rx_done), .rx_nodesc(rx_nodesc), .tx_poll(tx_poll), .irq(irq),
        .dma_ctrl(dma_ctrl), .bus_mode(bus_mode), .rx_cur(rx_cur), .tx_cur(tx_cur)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ev_mask(input logic t, input logic r, input logic n);
        logic [31:0] s = '0;
        if (t) s = s | 32'h0001_0001;
        if (r) s = s | 32'h0001_0040;
        if (n) s = s | 32'h0000_8080;
        return s;
    endfunction

    function automatic logic [31:0] model_read(input int w);
        if (w >= 1024)   return 32'h0;
        if (w == 'h008)  return 32'h0000_1012;
        if (w == 'h3C5)  return m_st;
        return m[w];
    endfunction

    function automatic logic model_irq();
        return |(m_st & m['h3C7]);
    endfunction

    // one bus cycle with optional engine requests; model updated afterwards
    task automatic cycle(input logic [AW-1:0] a, input logic w, input logic [31:0] d,
                         input logic t, input logic r, input logic n);
        int wd;
        @(negedge clk);
        bus_addr = a; bus_wr = w; bus_wdata = d;
        tx_done = t; rx_done = r; rx_nodesc = n;
        @(negedge clk);
        bus_wr = 1'b0; tx_done = 1'b0; rx_done = 1'b0; rx_nodesc = 1'b0;
        wd = int'(a >> 2);
        if (w && wd < 1024) begin
            case (wd)
                'h3C5: m_st = m_st & ~d;
                'h3C0: m[wd] = d & ~32'h1;
                'h3C1: ;
                'h3C3: begin m[wd] = d; m['h3D3] = d; end
                'h3C4: begin m[wd] = d; m['h3D2] = d; end
                default: m[wd] = d;
            endcase
        end
        m_st = m_st | ev_mask(t, r, n);
        check("R9 poll pulse", {31'h0, tx_poll}, {31'h0, (w && wd == 'h3C1)});
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    function automatic logic [AW-1:0] baddr(input int w, input int lo);
        return AW'((w << 2) | (lo & 3));
    endfunction

    function automatic int pick_word();
        int s = $urandom_range(0, 11);
        case (s)
            0: return 'h008;
            1: return 'h3C0;
            2: return 'h3C1;
            3: return 'h3C3;
            4: return 'h3C4;
            5: return 'h3C5;
            6: return 'h3C6;
            7: return 'h3C7;
            8: return 'h3D2;
            9: return 'h3D3;
            10: return $urandom_range(0, 1023);
            default: return 'h400 + $urandom_range(0, 'hBFF);
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        for (int i = 0; i < 1024; i++) m[i] = '0;
        m_st = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        rd(baddr('h3C5, 0), v); check("R11 status after reset", v, 32'h0);
        rd(baddr('h3C7, 0), v); check("R11 enable after reset", v, 32'h0);
        rd(baddr('h3D3, 0), v); check("R11 rx pointer after reset", v, 32'h0);
        check("R11 irq after reset", {31'h0, irq}, 32'h0);
        check("R11 poll after reset", {31'h0, tx_poll}, 32'h0);
        // R4: identification word
        rd(baddr('h008, 2), v); check("R4 ident read", v, 32'h0000_1012);
        cycle(baddr('h008, 0), 1'b1, 32'hDEAD_BEEF, 0, 0, 0);
        rd(baddr('h008, 0), v); check("R4 ident after write", v, 32'h0000_1012);

        // R5: bus mode bit 0 forced low
        cycle(baddr('h3C0, 0), 1'b1, 32'hFFFF_FFFF, 0, 0, 0);
        rd(baddr('h3C0, 0), v); check("R5 bus mode read", v, 32'hFFFF_FFFE);
        check("R5 bus mode port", bus_mode, 32'hFFFF_FFFE);

        // R6: base writes load current pointers
        cycle(baddr('h3C3, 0), 1'b1, 32'h1234_5678, 0, 0, 0);
        rd(baddr('h3D3, 0), v); check("R6 rx current word", v, 32'h1234_5678);
        rd(baddr('h3C3, 0), v); check("R6 rx base word", v, 32'h1234_5678);
        check("R6 rx_cur port", rx_cur, 32'h1234_5678);
        cycle(baddr('h3C4, 0), 1'b1, 32'h0BAD_F00C, 0, 0, 0);
        rd(baddr('h3D2, 0), v); check("R6 tx current word", v, 32'h0BAD_F00C);
        check("R6 tx_cur port", tx_cur, 32'h0BAD_F00C);

        // R9: poll trigger lasts one cycle and stores nothing
        cycle(baddr('h3C1, 0), 1'b1, 32'hFFFF_FFFF, 0, 0, 0);
        @(negedge clk);
        check("R9 poll back low", {31'h0, tx_poll}, 32'h0);
        rd(baddr('h3C1, 0), v); check("R9 poll word stores nothing", v, 32'h0);

        // R7 / R3 / R2: events, enable, clear
        cycle(baddr('h3C6, 0), 1'b1, 32'h0000_2002, 1, 0, 0);
        check("R10 control port", dma_ctrl, 32'h0000_2002);
        rd(baddr('h3C5, 0), v); check("R7 tx event bits", v, 32'h0001_0001);
        check("R3 irq masked", {31'h0, irq}, 32'h0);
        cycle(baddr('h3C7, 0), 1'b1, 32'h0000_0001, 0, 0, 0);
        check("R3 irq enabled", {31'h0, irq}, 32'h1);
        cycle(baddr('h3C5, 1), 1'b1, 32'h0000_0001, 0, 0, 0);
        rd(baddr('h3C5, 0), v); check("R2 partial clear", v, 32'h0001_0000);
        check("R3 irq after clear", {31'h0, irq}, 32'h0);
        cycle(baddr('h000, 0), 1'b0, 32'h0, 0, 0, 1);
        rd(baddr('h3C5, 0), v); check("R7 no descriptor bits", v, 32'h0001_8080);

        // R8: set wins over same-cycle clear
        cycle(baddr('h3C5, 0), 1'b1, 32'hFFFF_FFFF, 0, 1, 0);
        rd(baddr('h3C5, 0), v); check("R8 set beats clear", v, 32'h0001_0040);

        // R1: low bits ignored, outside window reads zero and writes nothing
        cycle(baddr('h010, 3), 1'b1, 32'hCAFE_0001, 0, 0, 0);
        rd(baddr('h010, 0), v); check("R1 low bits ignored", v, 32'hCAFE_0001);
        cycle(baddr('h400, 0), 1'b1, 32'h5555_AAAA, 0, 0, 0);
        rd(baddr('h400, 0), v); check("R1 outside reads zero", v, 32'h0);
        rd(baddr('h000, 0), v); check("R1 no alias onto word 0", v, 32'h0);

        // mixed random traffic against the model (R1..R10)
        for (int k = 0; k < 600; k++) begin
            int w, w2, lo;
            logic [31:0] d;
            w  = pick_word();
            lo = $urandom_range(0, 3);
            d  = $urandom();
            if (w == 'h3C7) d = d & 32'h0001_80C1 & $urandom();
            cycle(baddr(w, lo), ($urandom_range(0, 5) != 0), d,
                  ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
                  ($urandom_range(0, 5) == 0));
            rd(baddr(w, 0), v);
            check("R10 random readback", v, model_read(w));
            w2 = pick_word();
            rd(baddr(w2, $urandom_range(0, 3)), v);
            check("R1 random second read", v, model_read(w2));
            check("R3 random irq", {31'h0, irq}, {31'h0, model_irq()});
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule